// File: doc/BRIEF.md
# Serial Flash Read-Ahead Engine

This block reads a run of 32-bit words out of a serial NOR flash without processor involvement beyond setup. Software sets up a read command: the opcode, how many data lines each phase uses, the number of dummy cycles, and whether the address is three or four bytes wide. It then gives a start address and a word count and kicks the engine. The engine drives chip select and the serial clock. It shifts out the opcode and the address, waits out the dummy cycles, and gathers the returned bytes into little-endian words. Those words are queued in a small read FIFO.

Software watches two status outputs, busy and FIFO-empty, and pops words one at a time. Command settings are held in a staging copy and only move into the working copy when the enable bit is set again after being cleared. A session can therefore never pick up a half-written setup. A separate override register can force the data width and the address mode. A session never reads across a 16 MB boundary. When the FIFO is full, the engine holds the serial clock low until a word is removed, so no data is dropped.

Top module: `sfl_readahead`

## Requirements
- R1: After reset, busy is 0, fifo_empty is 1, flash_cs_n is 1 and flash_sck is 0.
- R2: A session lowers flash_cs_n and sends the 8-bit opcode, then the address, then the dummy cycles, then reads data. Every phase is sent MSB first. Outputs change while flash_sck is low and inputs are sampled on its rising edge. In 3-byte mode the address is START (register index 5) bits [23:0]. One-lane output uses io line 0.
- R3: The lane register (index 1) holds three width codes: data at bits [1:0], address at bits [17:16] and command at bits [25:24]. Code 0 means 1 line, code 1 means 2 lines, and codes 2 and 3 mean 4 lines. A w-line phase uses io[w-1:0], with the higher-numbered line carrying the earlier bit. One-lane data input is taken from io line 1. flash_io_oe is set for the lanes in use during the opcode and address phases, and is 0 during the dummy and data phases.
- R4: The phase register (index 2) holds the dummy cycle count in bits [7:0]; bit 16 selects 4-byte addressing. In 4-byte mode the address sent is the upper byte register (index 4) bits [7:0] followed by START[23:0].
- R5: Writes to registers 1, 2 and 3 reach the engine only when the enable register (index 0) bit 0 is written with 1 while it holds 0. Otherwise the previous settings stay in use.
- R6: Writing bit 0 of the control register (index 7) starts a session of COUNT (index 6) words. The start is ignored while busy, and a start with COUNT equal to 0 does nothing.
- R7: The first byte received lands in data_word bits [7:0] and the fourth in bits [31:24].
- R8: busy is 1 from the cycle after a start until the session ends. data_pop removes one word. A pop while fifo_empty is 1 has no effect.
- R9: When the FIFO is full at a word boundary, flash_sck stays low until a word is popped, and no data is lost.
- R10: When the last word has been read, flash_cs_n returns high and busy clears. Words still in the FIFO stay there until they are popped.
- R11: A session stops early once its next word would start at or past 2^24 within the 24-bit address.
- R12: The override register (index 8) works as follows when its bit 0 is 1. Bit 3 selects quad data, and otherwise bit 1 selects dual data, and otherwise data uses one line. Bit 2 selects the address mode. These replace the staged data width and address mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| data_pop | input | 1 | Remove the head word of the FIFO |
| data_word | output | 32 | Head word of the FIFO |
| busy | output | 1 | Session in progress |
| fifo_empty | output | 1 | FIFO holds no word |
| flash_sck | output | 1 | Serial clock |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_io_out | output | 4 | Data lines driven to the flash |
| flash_io_oe | output | 4 | Output enable per data line |
| flash_io_in | input | 4 | Data lines from the flash |

## Verification
A flash model in the bench decodes the opcode and address at the widths it expects and returns bytes computed from their address. Sessions are run with:
- single-lane phases;
- mixed 1/2/4-lane phases with dummy cycles;
- 4-byte addressing;
- the override forcing quad data.

Each pattern shows whether the shifts, the cycle counts and the byte order follow the lane codes. A staged write without the enable toggle tells held settings apart from live ones. A start placed just below the 16 MB line separates an early stop from a full-length read. Runs with the FIFO left undrained tell a clock stall apart from dropped words, and show that words are kept after the session ends.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic [1:0] cmd_lw;
        logic [1:0] addr_lw;
        logic [1:0] data_lw;
        logic [7:0] dummy;
        logic       wide_addr;
        logic [7:0] opcode;
    } flash_cfg_t;

    localparam flash_cfg_t CFG_RESET = '{
        cmd_lw: 2'd0, addr_lw: 2'd0, data_lw: 2'd0,
        dummy: 8'd0, wide_addr: 1'b0, opcode: 8'h03
    };

    localparam logic [3:0] IDX_ENABLE   = 4'd0;
    localparam logic [3:0] IDX_LANES    = 4'd1;
    localparam logic [3:0] IDX_PHASE    = 4'd2;
    localparam logic [3:0] IDX_OPCODE   = 4'd3;
    localparam logic [3:0] IDX_UPPER    = 4'd4;
    localparam logic [3:0] IDX_START    = 4'd5;
    localparam logic [3:0] IDX_COUNT    = 4'd6;
    localparam logic [3:0] IDX_CTRL     = 4'd7;
    localparam logic [3:0] IDX_OVERRIDE = 4'd8;

    // serial clock cycles needed to move nbits at the given lane code
    function automatic logic [7:0] lane_cycles(input logic [5:0] nbits, input logic [1:0] code);
        case (code)
            2'd0:    lane_cycles = {2'b00, nbits};
            2'd1:    lane_cycles = {3'b000, nbits[5:1]};
            default: lane_cycles = {4'b0000, nbits[5:2]};
        endcase
    endfunction

endpackage

// File: rtl/sfl_regs.sv
module sfl_regs
    import sfl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [3:0]       addr,
    input  logic [31:0]      wdata,
    output flash_cfg_t       eff_cfg,
    output logic [7:0]       upper,
    output logic [23:0]      start_addr,
    output logic [CNT_W-1:0] word_count,
    output logic             go
);

    typedef struct packed {
        logic             en;
        flash_cfg_t       staged;
        flash_cfg_t       active;
        logic [3:0]       ovr;
        logic [7:0]       upper;
        logic [23:0]      start;
        logic [CNT_W-1:0] count;
    } regs_t;

    regs_t r_d, r_q;
    logic  load;

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        go   = 1'b0;
        if (we) begin
            case (addr)
                IDX_ENABLE: begin
                    load   = wdata[0] && !r_q.en;
                    r_d.en = wdata[0];
                end
                IDX_LANES: begin
                    r_d.staged.data_lw = wdata[1:0];
                    r_d.staged.addr_lw = wdata[17:16];
                    r_d.staged.cmd_lw  = wdata[25:24];
                end
                IDX_PHASE: begin
                    r_d.staged.dummy     = wdata[7:0];
                    r_d.staged.wide_addr = wdata[16];
                end
                IDX_OPCODE:   r_d.staged.opcode = wdata[7:0];
                IDX_UPPER:    r_d.upper = wdata[7:0];
                IDX_START:    r_d.start = wdata[23:0];
                IDX_COUNT:    r_d.count = wdata[CNT_W-1:0];
                IDX_CTRL:     go = wdata[0];
                IDX_OVERRIDE: r_d.ovr = wdata[3:0];
                default: ;
            endcase
        end
        if (load) r_d.active = r_q.staged;

        eff_cfg = r_q.active;
        if (r_q.ovr[0]) begin
            eff_cfg.data_lw   = r_q.ovr[3] ? 2'd2 : (r_q.ovr[1] ? 2'd1 : 2'd0);
            eff_cfg.wide_addr = r_q.ovr[2];
        end
        upper      = r_q.upper;
        start_addr = r_q.start;
        word_count = r_q.count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{en: 1'b0, staged: CFG_RESET, active: CFG_RESET, ovr: 4'd0,
                     upper: 8'd0, start: 24'd0, count: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R5: working settings move only on an enable 0->1 write
    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == IDX_ENABLE && wdata[0] && !r_q.en) |=> $stable(r_q.active));

endmodule

// File: rtl/sfl_fifo.sv
module sfl_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d    = f_q;
        do_pop = pop && (f_q.cnt != '0);
        if (push) begin
            f_d.mem[f_q.wp] = push_word;
            f_d.wp          = bump(f_q.wp);
        end
        if (do_pop) f_d.rp = bump(f_q.rp);
        f_d.cnt = f_q.cnt + CW'(push) - CW'(do_pop);
        head  = f_q.mem[f_q.rp];
        empty = (f_q.cnt == '0);
        full  = (f_q.cnt == CW'(DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (f_q.cnt < CW'(DEPTH)));

    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/sfl_seq.sv
module sfl_seq
    import sfl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  flash_cfg_t       cfg,
    input  logic [7:0]       upper,
    input  logic [23:0]      start_addr,
    input  logic [CNT_W-1:0] word_count,
    input  logic             go,
    input  logic             fifo_full,
    input  logic [3:0]       io_in,
    output logic             push,
    output logic [31:0]      push_word,
    output logic             busy,
    output logic             sck,
    output logic             cs_n,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe
);

    typedef struct packed {
        phase_e           st;
        logic             sck;
        logic [31:0]      sh;
        logic [31:0]      rx;
        logic [7:0]       cnt;
        logic [CNT_W-1:0] left;
        logic [24:0]      addr;
        logic [7:0]       up;
        flash_cfg_t       cfg;
    } seq_t;

    seq_t        s_d, s_q;
    logic [1:0]  lw;
    logic [7:0]  word_cyc;
    logic [24:0] addr_nx;

    always_comb begin
        s_d  = s_q;
        push = 1'b0;
        case (s_q.st)
            PH_CMD:  lw = s_q.cfg.cmd_lw;
            PH_ADDR: lw = s_q.cfg.addr_lw;
            default: lw = s_q.cfg.data_lw;
        endcase
        word_cyc = lane_cycles(6'd32, s_q.cfg.data_lw);
        addr_nx  = s_q.addr + 25'd4;

        if (s_q.st == PH_IDLE) begin
            if (go && word_count != '0) begin
                s_d.st   = PH_CMD;
                s_d.sck  = 1'b0;
                s_d.cfg  = cfg;
                s_d.up   = upper;
                s_d.sh   = {cfg.opcode, 24'h0};
                s_d.cnt  = lane_cycles(6'd8, cfg.cmd_lw);
                s_d.left = word_count;
                s_d.addr = {1'b0, start_addr};
            end
        end else if (!s_q.sck) begin
            if (!(s_q.st == PH_DATA && s_q.cnt == word_cyc && fifo_full)) begin
                s_d.sck = 1'b1;
                if (s_q.st == PH_DATA) begin
                    case (s_q.cfg.data_lw)
                        2'd0:    s_d.rx = {s_q.rx[30:0], io_in[1]};
                        2'd1:    s_d.rx = {s_q.rx[29:0], io_in[1:0]};
                        default: s_d.rx = {s_q.rx[27:0], io_in};
                    endcase
                end
            end
        end else begin
            s_d.sck = 1'b0;
            s_d.cnt = s_q.cnt - 8'd1;
            case (lw)
                2'd0:    s_d.sh = s_q.sh << 1;
                2'd1:    s_d.sh = s_q.sh << 2;
                default: s_d.sh = s_q.sh << 4;
            endcase
            if (s_q.cnt == 8'd1) begin
                case (s_q.st)
                    PH_CMD: begin
                        s_d.st  = PH_ADDR;
                        s_d.sh  = s_q.cfg.wide_addr ? {s_q.up, s_q.addr[23:0]}
                                                    : {s_q.addr[23:0], 8'h0};
                        s_d.cnt = lane_cycles(s_q.cfg.wide_addr ? 6'd32 : 6'd24,
                                              s_q.cfg.addr_lw);
                    end
                    PH_ADDR: begin
                        if (s_q.cfg.dummy != 8'd0) begin
                            s_d.st  = PH_DUMMY;
                            s_d.cnt = s_q.cfg.dummy;
                        end else begin
                            s_d.st  = PH_DATA;
                            s_d.cnt = word_cyc;
                        end
                    end
                    PH_DUMMY: begin
                        s_d.st  = PH_DATA;
                        s_d.cnt = word_cyc;
                    end
                    default: begin
                        push     = 1'b1;
                        s_d.left = s_q.left - 1'b1;
                        s_d.addr = addr_nx;
                        s_d.cnt  = word_cyc;
                        if (s_q.left == 1 || addr_nx[24]) s_d.st = PH_IDLE;
                    end
                endcase
            end
        end

        push_word = {s_q.rx[7:0], s_q.rx[15:8], s_q.rx[23:16], s_q.rx[31:24]};
        busy = (s_q.st != PH_IDLE);
        cs_n = (s_q.st == PH_IDLE);
        sck  = s_q.sck;
        case (lw)
            2'd0:    io_out = {3'b000, s_q.sh[31]};
            2'd1:    io_out = {2'b00, s_q.sh[31:30]};
            default: io_out = s_q.sh[31:28];
        endcase
        if (s_q.st == PH_CMD || s_q.st == PH_ADDR) begin
            case (lw)
                2'd0:    io_oe = 4'b0001;
                2'd1:    io_oe = 4'b0011;
                default: io_oe = 4'b1111;
            endcase
        end else begin
            io_oe = 4'b0000;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: PH_IDLE, sck: 1'b0, sh: 32'h0, rx: 32'h0, cnt: 8'h0,
                     left: '0, addr: 25'h0, up: 8'h0, cfg: CFG_RESET};
        end else begin
            s_q <= s_d;
        end
    end

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == PH_DATA && !s_q.sck && s_q.cnt == word_cyc && fifo_full) |=> !sck);

    assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == PH_IDLE && word_count == '0) |=> (s_q.st == PH_IDLE));

endmodule

// File: rtl/sfl_readahead.sv
module sfl_readahead
    import sfl_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        data_pop,
    output logic [31:0] data_word,
    output logic        busy,
    output logic        fifo_empty,
    output logic        flash_sck,
    output logic        flash_cs_n,
    output logic [3:0]  flash_io_out,
    output logic [3:0]  flash_io_oe,
    input  logic [3:0]  flash_io_in
);

    flash_cfg_t       eff_cfg;
    logic [7:0]       upper;
    logic [23:0]      start_addr;
    logic [CNT_W-1:0] word_count;
    logic             go;
    logic             push;
    logic [31:0]      push_word;
    logic             fifo_full;

    sfl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .eff_cfg    (eff_cfg),
        .upper      (upper),
        .start_addr (start_addr),
        .word_count (word_count),
        .go         (go)
    );

    sfl_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (eff_cfg),
        .upper      (upper),
        .start_addr (start_addr),
        .word_count (word_count),
        .go         (go),
        .fifo_full  (fifo_full),
        .io_in      (flash_io_in),
        .push       (push),
        .push_word  (push_word),
        .busy       (busy),
        .sck        (flash_sck),
        .cs_n       (flash_cs_n),
        .io_out     (flash_io_out),
        .io_oe      (flash_io_oe)
    );

    sfl_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .pop       (data_pop),
        .head      (data_word),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

endmodule

// File: tb/sim_sfl_readahead.sv
module sim_sfl_readahead;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        data_pop = 1'b0;
    logic [31:0] data_word;
    logic        busy, fifo_empty, flash_sck, flash_cs_n;
    logic [3:0]  flash_io_out, flash_io_oe;
    logic [3:0]  flash_io_in = 4'd0;

    int checks = 0;
    int errors = 0;

    // flash model settings: what the design is expected to use
    int mwc = 1, mwa = 1, mwd = 1, mdummy = 0;
    bit ma4 = 0;
    int ncyc = 0, sessions = 0;
    logic [7:0]  cap_cmd = 8'd0;
    logic [31:0] cap_addr = 32'd0;

    logic [31:0] exp_q[$];
    bit mon_en = 1'b1;
    bit force_pop = 1'b0;

    sfl_readahead u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .data_pop(data_pop), .data_word(data_word),
        .busy(busy), .fifo_empty(fifo_empty), .flash_sck(flash_sck),
        .flash_cs_n(flash_cs_n), .flash_io_out(flash_io_out),
        .flash_io_oe(flash_io_oe), .flash_io_in(flash_io_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] flash_byte(input logic [31:0] a);
        flash_byte = a[7:0] ^ (a[15:8] * 8'd3) ^ a[23:16] ^ a[31:24] ^ 8'h5C;
    endfunction

    function automatic int pre_cycles();
        pre_cycles = 8 / mwc + (ma4 ? 32 : 24) / mwa + mdummy;
    endfunction

    // ---------------- flash model ----------------
    always @(negedge flash_cs_n) begin
        ncyc = 0; cap_cmd = 8'd0; cap_addr = 32'd0; sessions++;
    end

    always @(posedge flash_sck) begin
        if (!flash_cs_n) begin
            logic [3:0] b;
            b = (mwc == 1) ? {3'b0, flash_io_out[0]} : (mwc == 2) ? {2'b0, flash_io_out[1:0]} : flash_io_out;
            if (ncyc < 8 / mwc) begin
                cap_cmd = (cap_cmd << mwc) | b[3:0];
            end else if (ncyc < 8 / mwc + (ma4 ? 32 : 24) / mwa) begin
                b = (mwa == 1) ? {3'b0, flash_io_out[0]} : (mwa == 2) ? {2'b0, flash_io_out[1:0]} : flash_io_out;
                cap_addr = (cap_addr << mwa) | 32'(b);
            end
            ncyc++;
        end
    end

    always @(negedge flash_sck) begin
        if (!flash_cs_n && ncyc >= pre_cycles()) begin
            int k;
            int top;
            logic [7:0]  by;
            logic [31:0] base;
            k    = (ncyc - pre_cycles()) * mwd;
            base = ma4 ? cap_addr : {8'h0, cap_addr[23:0]};
            by   = flash_byte(base + 32'(k / 8));
            top  = 7 - (k % 8);
            if (mwd == 1)      flash_io_in = {2'b00, by[top], 1'b0};
            else if (mwd == 2) flash_io_in = 4'((by >> (top - 1)) & 8'h3);
            else               flash_io_in = 4'((by >> (top - 3)) & 8'hF);
        end
    end

    // ---------------- scoreboard monitor ----------------
    always @(negedge clk) begin
        if (mon_en && !fifo_empty) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected word", data_word, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(data_word == e, "R7 data word", data_word, e);
            end
            data_pop = 1'b1;
        end else begin
            data_pop = force_pop;
        end
    end

    // ---------------- driver tasks ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic cfg(input logic [31:0] lanes, input logic [31:0] phase, input logic [7:0] op);
        wr(4'd0, 32'd0);
        wr(4'd1, lanes);
        wr(4'd2, phase);
        wr(4'd3, {24'd0, op});
        wr(4'd0, 32'd1);
    endtask

    int s0;

    task automatic kick(input logic [23:0] st, input int cnt, input logic [31:0] base, input int nexp);
        for (int i = 0; i < nexp; i++) begin
            logic [31:0] w;
            for (int j = 0; j < 4; j++) w[8*j +: 8] = flash_byte(base + 32'(4*i + j));
            exp_q.push_back(w);
        end
        wr(4'd5, {8'd0, st});
        wr(4'd6, 32'(cnt));
        s0 = sessions;
        wr(4'd7, 32'd1);
        chk(busy == 1'b1, "R8 busy after start", 32'(busy), 32'd1);
    endtask

    task automatic finish_session(input logic [7:0] op, input logic [31:0] addr_exp, input int nexp, input string tag);
        while (busy) @(negedge clk);
        chk(flash_cs_n == 1'b1, "R10 cs high at end", 32'(flash_cs_n), 32'd1);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(cap_cmd == op, {tag, " opcode"}, 32'(cap_cmd), 32'(op));
        chk((ma4 ? cap_addr : {8'h0, cap_addr[23:0]}) == addr_exp, {tag, " address"}, cap_addr, addr_exp);
        chk(ncyc == pre_cycles() + nexp * (32 / mwd), {tag, " sck cycles"}, 32'(ncyc), 32'(pre_cycles() + nexp * (32 / mwd)));
        chk(sessions == s0 + 1, {tag, " one session"}, 32'(sessions), 32'(s0 + 1));
        chk(fifo_empty == 1'b1, {tag, " fifo drained"}, 32'(fifo_empty), 32'd1);
    endtask

    task automatic model(input int wc, input int wa, input int wd, input int dm, input bit a4);
        mwc = wc; mwa = wa; mwd = wd; mdummy = dm; ma4 = a4;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
        chk(fifo_empty == 1'b1, "R1 fifo_empty", 32'(fifo_empty), 32'd1);
        chk(flash_cs_n == 1'b1, "R1 cs_n", 32'(flash_cs_n), 32'd1);
        chk(flash_sck == 1'b0, "R1 sck", 32'(flash_sck), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R7: all single lane, 3-byte address, no dummy
        cfg(32'h0000_0000, 32'h0, 8'h03);
        model(1, 1, 1, 0, 0);
        kick(24'h001230, 4, 32'h001230, 4);
        finish_session(8'h03, 32'h001230, 4, "R2");

        // R3: command 1 lane, address 2 lanes, data 4 lanes, 8 dummy cycles
        cfg(32'h0001_0002, 32'h0000_0008, 8'h6B);
        model(1, 2, 4, 8, 0);
        kick(24'h00A004, 3, 32'h00A004, 3);
        finish_session(8'h6B, 32'h00A004, 3, "R3");

        // R4: 4-byte address with upper byte, all phases dual, 6 dummy cycles
        cfg(32'h0101_0001, 32'h0001_0006, 8'hEC);
        wr(4'd4, 32'h12);
        model(2, 2, 2, 6, 1);
        kick(24'h345670, 2, 32'h12345670, 2);
        finish_session(8'hEC, 32'h12345670, 2, "R4");

        // R5: opcode staged without enable toggle is not used
        wr(4'd3, 32'h0B);
        kick(24'h000100, 1, 32'h12000100, 1);
        finish_session(8'hEC, 32'h12000100, 1, "R5 held");
        wr(4'd0, 32'd0);
        wr(4'd0, 32'd1);
        kick(24'h000100, 1, 32'h12000100, 1);
        finish_session(8'h0B, 32'h12000100, 1, "R5 loaded");

        // R12: override forces quad data and 4-byte address
        cfg(32'h0, 32'h0, 8'h03);
        wr(4'd4, 32'h05);
        wr(4'd8, 32'hD);
        model(1, 1, 4, 0, 1);
        kick(24'h000040, 2, 32'h05000040, 2);
        finish_session(8'h03, 32'h05000040, 2, "R12");
        wr(4'd8, 32'h0);

        // R11: 16 MB boundary stops after two of five words
        model(1, 1, 1, 0, 0);
        kick(24'hFFFFF8, 5, 32'h00FFFFF8, 2);
        finish_session(8'h03, 32'h00FFFFF8, 2, "R11");

        // R6: zero count does nothing
        wr(4'd6, 32'd0);
        s0 = sessions;
        wr(4'd7, 32'd1);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R6 zero count busy", 32'(busy), 32'd0);
        chk(sessions == s0, "R6 zero count no session", 32'(sessions), 32'(s0));

        // R6: start while busy is ignored
        kick(24'h000200, 2, 32'h00000200, 2);
        repeat (30) @(negedge clk);
        wr(4'd5, 32'h000300);
        wr(4'd7, 32'd1);
        finish_session(8'h03, 32'h00000200, 2, "R6 busy start");

        // R8: pop while empty is ignored
        mon_en = 1'b0;
        force_pop = 1'b1;
        repeat (3) @(negedge clk);
        force_pop = 1'b0;
        @(negedge clk);
        chk(fifo_empty == 1'b1, "R8 empty pop", 32'(fifo_empty), 32'd1);
        mon_en = 1'b1;
        kick(24'h000500, 1, 32'h00000500, 1);
        finish_session(8'h03, 32'h00000500, 1, "R8 after empty pop");

        // R9: FIFO full stalls the clock, nothing lost
        mon_en = 1'b0;
        kick(24'h000800, 8, 32'h00000800, 8);
        repeat (400) @(negedge clk);
        chk(busy == 1'b1, "R9 busy while stalled", 32'(busy), 32'd1);
        chk(fifo_empty == 1'b0, "R9 fifo holds words", 32'(fifo_empty), 32'd0);
        begin
            int ticks;
            ticks = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (flash_sck) ticks++;
            end
            chk(ticks == 0, "R9 sck held low", 32'(ticks), 32'd0);
        end
        mon_en = 1'b1;
        finish_session(8'h03, 32'h00000800, 8, "R9");

        // R10: words retained after session end
        mon_en = 1'b0;
        kick(24'h000900, 2, 32'h00000900, 2);
        while (busy) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(flash_cs_n == 1'b1, "R10 cs_n idle", 32'(flash_cs_n), 32'd1);
        chk(fifo_empty == 1'b0, "R10 words kept", 32'(fifo_empty), 32'd0);
        mon_en = 1'b1;
        finish_session(8'h03, 32'h00000900, 2, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule